// File: doc/BRIEF.md
# Banked Flash Window Controller

This block lets a processor reach a large banked flash array through the upper half of its 16-bit address space. An access to the 32K-word window (processor address bit 15 set) is combined with the upper flash address bits held in one of two window latches. A read of the data window takes the read latch. A write, or an instruction fetch from the window, takes the write latch. Each latch also carries the chip-select index and the bank bit. The controller then runs a short, fixed access sequence on the flash pins. It decodes one of eight active-low chip enables, pulses the read or write strobe of the selected bank, and captures the read data. The data bus can be inverted in both directions.

Processor accesses use a valid/ready request channel. `acc_ready` is high only while the controller is idle, and a request is taken on a clock edge where `acc_valid` and `acc_ready` are both high. The requester holds its request stable until it is taken. Read responses come out as a single-cycle `rsp_valid` pulse with no back-pressure, so the requester must be able to accept data on any cycle. Latches and control bits are set through a plain register port. A sequential mode turns two of the high address pins into command-latch and address-latch enables for command-style flash devices, and drives the chip enables as a level from the read latch.

Top module: `flash_window_ctrl`

## Requirements
- R1: A request with `acc_addr[15]`=1 and `acc_write`=0, `acc_prog`=0 drives `fl_addr` = {read latch[9:0], acc_addr[14:0]} during the access. The response data is the value sampled on `fl_rdata` while the read strobe is low.
- R2: A window write (`acc_write`=1), or a window fetch (`acc_prog`=1), takes `fl_addr[24:15]`, the chip enable and the bank from the write latch instead of the read latch.
- R3: Latch bits 7:5 select the single low chip enable: 000→0, 001→2, 010→4, 011→6, 100→1, 101→3, 110→5, 111→7. In random mode all chip enables are high when no access is in progress.
- R4: Latch bit 8 = 0 strobes `fl_rd_n[0]`/`fl_wr_n[0]`, and bit 8 = 1 strobes `fl_rd_n[1]`/`fl_wr_n[1]`. Only one strobe pin is low at a time.
- R5: A write strobe is low for one clock when control bit 0 is 0, and for two clocks when it is 1.
- R6: A read strobe is low for exactly one clock. In random mode the chip enable is low one clock before any strobe falls and stays low for one clock after the strobe rises.
- R7: With mode register (select 3) bit 0 = 0, `fl_wdata` is the bitwise inverse of the request data and the response is the inverse of `fl_rdata`. With bit 0 = 1, both pass through unchanged.
- R8: A request with `acc_addr[15]`=0 is accepted but drives no strobe, no chip enable and no response.
- R9: With control bit 1 = 1 (sequential mode), `fl_addr[19]` follows read-latch bit 4 and `fl_addr[18]` follows read-latch bit 3. Chip enables decode read-latch bits 7:5 and are driven only while control bit 2 is 1; otherwise all are high.
- R10: The control register (select 2) resets to 8Ah. Its bit 6 reads the ready/busy input (1 ready, 0 busy) after a two-flop synchronizer.
- R11: `fl_pd_n[0]` equals control bit 7 and `fl_pd_n[1]` equals control bit 3, each active low.
- R12: `acc_ready` is high only when no flash access is in progress. Each window read or fetch yields exactly one `rsp_valid` pulse, in the clock right after its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Controller idle, request taken |
| acc_write | input | 1 | 1 = write access |
| acc_prog | input | 1 | 1 = instruction fetch (read through write latch) |
| acc_addr | input | 16 | Processor address |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 read latch, 1 write latch, 2 control, 3 mode |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Selected register contents |
| fl_addr | output | 25 | Flash address pins |
| fl_ce_n | output | 8 | Chip enables, active low |
| fl_rd_n | output | 2 | Per-bank read strobes, active low |
| fl_wr_n | output | 2 | Per-bank write strobes, active low |
| fl_wdata | output | 16 | Flash write data |
| fl_doe | output | 1 | Flash data bus drive enable |
| fl_rdata | input | 16 | Flash read data |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| fl_pd_n | output | 2 | Per-bank deep power-down, active low |

## Verification
The hardest case to reach from the ports is a fetch whose write latch differs from the read latch in chip select, bank and low address bit. Only then can a fetch that wrongly took the read latch be told apart from a correct one. The stimulus loads the two latches with different values just before the fetch. The flash model also returns data that depends on the address pins, so a wrong latch changes the response as well as the strobe pattern. The two-clock write pulse is covered in the same way: the width bit is switched between back-to-back writes, and the monitor counts the strobe length together with the chip-enable hold cycle that follows.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    FW_IDLE  = 2'd0,
    FW_SETUP = 2'd1,
    FW_STRB  = 2'd2,
    FW_HOLD  = 2'd3
  } fw_state_e;

  // control register image, MSB first
  typedef struct packed {
    logic       pd0_off;
    logic       rdy;
    logic [1:0] kind;
    logic       pd1_off;
    logic       ce_en;
    logic       seq;
    logic       wide;
  } fw_ctrl_t;

  localparam logic [7:0] FW_CTRL_RST = 8'h8A;

  localparam logic [1:0] SEL_RLATCH = 2'd0;
  localparam logic [1:0] SEL_WLATCH = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_MODE   = 2'd3;

endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs
  import fw_pkg::*;
#(
  parameter int LATCH_W = 10,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               fl_rdy,
  output logic [LATCH_W-1:0] rd_latch,
  output logic [LATCH_W-1:0] wr_latch,
  output logic               seq_mode,
  output logic               ce_en,
  output logic               wide,
  output logic               pd0_off,
  output logic               pd1_off,
  output logic               pass_data
);

  localparam int CTRL_W = $bits(fw_ctrl_t);

  fw_ctrl_t   ctrl_q;
  fw_ctrl_t   ctrl_view;
  logic [1:0] rdy_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sync <= 2'b00;
    else        rdy_sync <= {rdy_sync[0], fl_rdy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_latch  <= '0;
      wr_latch  <= '0;
      ctrl_q    <= fw_ctrl_t'(FW_CTRL_RST);
      pass_data <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_RLATCH: rd_latch  <= cfg_wdata[LATCH_W-1:0];
        SEL_WLATCH: wr_latch  <= cfg_wdata[LATCH_W-1:0];
        SEL_CTRL:   ctrl_q    <= fw_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        default:    pass_data <= cfg_wdata[0];
      endcase
    end
  end

  always_comb begin
    ctrl_view     = ctrl_q;
    ctrl_view.rdy = rdy_sync[1];
  end

  always_comb begin
    case (cfg_sel)
      SEL_RLATCH: cfg_rdata = DATA_W'(rd_latch);
      SEL_WLATCH: cfg_rdata = DATA_W'(wr_latch);
      SEL_CTRL:   cfg_rdata = DATA_W'(ctrl_view);
      default:    cfg_rdata = DATA_W'(pass_data);
    endcase
  end

  assign seq_mode = ctrl_q.seq;
  assign ce_en    = ctrl_q.ce_en;
  assign wide     = ctrl_q.wide;
  assign pd0_off  = ctrl_q.pd0_off;
  assign pd1_off  = ctrl_q.pd1_off;

endmodule

// File: rtl/fw_ce_decode.sv
module fw_ce_decode #(
  parameter int NUM_CE = 8,
  localparam int SEL_W = $clog2(NUM_CE)
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CE-1:0] ce_n
);

  // the select field is rotated left by one: its top bit picks odd/even
  logic [SEL_W-1:0] idx;
  assign idx = {sel[SEL_W-2:0], sel[SEL_W-1]};

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    assign ce_n[g] = !(en && (idx == SEL_W'(g)));
  end

endmodule

// File: rtl/fw_access_fsm.sv
module fw_access_fsm
  import fw_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int DATA_W   = 16,
  parameter int LATCH_W  = 10,
  parameter int BANK_BIT = 8,
  parameter int NUM_BANK = 2,
  localparam int WIN_AW  = CPU_AW - 1,
  localparam int BANK_W  = $clog2(NUM_BANK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic               acc_write,
  input  logic               acc_prog,
  input  logic [CPU_AW-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic [LATCH_W-1:0] rd_latch,
  input  logic [LATCH_W-1:0] wr_latch,
  input  logic               wide,
  input  logic [DATA_W-1:0]  fl_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_raw,
  output logic               busy,
  output logic [LATCH_W-1:0] cap_latch,
  output logic [WIN_AW-1:0]  cap_lo,
  output logic [DATA_W-1:0]  cap_wdata,
  output logic               doe,
  output logic [NUM_BANK-1:0] rd_n,
  output logic [NUM_BANK-1:0] wr_n
);

  fw_state_e st;
  logic      is_wr;
  logic      wide_q;
  logic      second;
  logic [BANK_W-1:0] bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FW_IDLE;
      is_wr     <= 1'b0;
      wide_q    <= 1'b0;
      second    <= 1'b0;
      cap_latch <= '0;
      cap_lo    <= '0;
      cap_wdata <= '0;
      rsp_raw   <= '0;
    end else begin
      case (st)
        FW_IDLE: begin
          if (acc_valid && acc_addr[CPU_AW-1]) begin
            is_wr     <= acc_write;
            cap_latch <= (acc_write || acc_prog) ? wr_latch : rd_latch;
            cap_lo    <= acc_addr[WIN_AW-1:0];
            cap_wdata <= acc_wdata;
            wide_q    <= acc_write && wide;
            st        <= FW_SETUP;
          end
        end
        FW_SETUP: begin
          second <= 1'b0;
          st     <= FW_STRB;
        end
        FW_STRB: begin
          if (!is_wr) rsp_raw <= fl_rdata;
          if (wide_q && !second) second <= 1'b1;
          else                   st     <= FW_HOLD;
        end
        default: st <= FW_IDLE;
      endcase
    end
  end

  assign acc_ready = (st == FW_IDLE);
  assign busy      = (st != FW_IDLE);
  assign rsp_valid = (st == FW_HOLD) && !is_wr;
  assign doe       = busy && is_wr;
  assign bank      = cap_latch[BANK_BIT +: BANK_W];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign rd_n[b] = !((st == FW_STRB) && !is_wr && (bank == BANK_W'(b)));
    assign wr_n[b] = !((st == FW_STRB) &&  is_wr && (bank == BANK_W'(b)));
  end

endmodule

// File: rtl/flash_window_ctrl.sv
module flash_window_ctrl #(
  parameter int CPU_AW   = 16,
  parameter int DATA_W   = 16,
  parameter int LATCH_W  = 10,
  parameter int NUM_CE   = 8,
  parameter int NUM_BANK = 2,
  parameter int CE_LSB   = 5,
  parameter int BANK_BIT = 8,
  parameter int CLE_BIT  = 4,
  parameter int ALE_BIT  = 3,
  localparam int WIN_AW  = CPU_AW - 1,
  localparam int FA_W    = WIN_AW + LATCH_W,
  localparam int SEL_W   = $clog2(NUM_CE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic                acc_write,
  input  logic                acc_prog,
  input  logic [CPU_AW-1:0]   acc_addr,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic [FA_W-1:0]     fl_addr,
  output logic [NUM_CE-1:0]   fl_ce_n,
  output logic [NUM_BANK-1:0] fl_rd_n,
  output logic [NUM_BANK-1:0] fl_wr_n,
  output logic [DATA_W-1:0]   fl_wdata,
  output logic                fl_doe,
  input  logic [DATA_W-1:0]   fl_rdata,
  input  logic                fl_rdy,
  output logic [NUM_BANK-1:0] fl_pd_n
);

  logic [LATCH_W-1:0] rd_latch, wr_latch, cap_latch, addr_hi;
  logic [WIN_AW-1:0]  cap_lo;
  logic [DATA_W-1:0]  cap_wdata, rsp_raw;
  logic               seq_mode, ce_en, wide, pd0_off, pd1_off, pass_data, busy;
  logic               dec_en;
  logic [SEL_W-1:0]   dec_sel;

  fw_cfg_regs #(.LATCH_W(LATCH_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fl_rdy(fl_rdy),
    .rd_latch(rd_latch), .wr_latch(wr_latch),
    .seq_mode(seq_mode), .ce_en(ce_en), .wide(wide),
    .pd0_off(pd0_off), .pd1_off(pd1_off), .pass_data(pass_data)
  );

  fw_access_fsm #(
    .CPU_AW(CPU_AW), .DATA_W(DATA_W), .LATCH_W(LATCH_W),
    .BANK_BIT(BANK_BIT), .NUM_BANK(NUM_BANK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_prog(acc_prog),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_latch(rd_latch), .wr_latch(wr_latch), .wide(wide),
    .fl_rdata(fl_rdata),
    .rsp_valid(rsp_valid), .rsp_raw(rsp_raw),
    .busy(busy), .cap_latch(cap_latch), .cap_lo(cap_lo), .cap_wdata(cap_wdata),
    .doe(fl_doe), .rd_n(fl_rd_n), .wr_n(fl_wr_n)
  );

  // sequential mode: chip enable is a level set from the read latch
  assign dec_en  = seq_mode ? ce_en : busy;
  assign dec_sel = seq_mode ? rd_latch[CE_LSB +: SEL_W] : cap_latch[CE_LSB +: SEL_W];

  fw_ce_decode #(.NUM_CE(NUM_CE)) u_ce (
    .en(dec_en), .sel(dec_sel), .ce_n(fl_ce_n)
  );

  always_comb begin
    addr_hi = cap_latch;
    if (seq_mode) begin
      addr_hi[CLE_BIT] = rd_latch[CLE_BIT];
      addr_hi[ALE_BIT] = rd_latch[ALE_BIT];
    end
  end

  assign fl_addr  = {addr_hi, cap_lo};
  assign fl_wdata = pass_data ? cap_wdata : ~cap_wdata;
  assign rsp_data = pass_data ? rsp_raw : ~rsp_raw;

  if (NUM_BANK == 2) begin : g_pd2
    assign fl_pd_n = {pd1_off, pd0_off};
  end else begin : g_pdn
    assign fl_pd_n = {NUM_BANK{pd0_off & pd1_off}};
  end

endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int NUM_CE   = 8,
  parameter int NUM_BANK = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                seq_mode,
  input logic                acc_ready,
  input logic                rsp_valid,
  input logic [NUM_CE-1:0]   fl_ce_n,
  input logic [NUM_BANK-1:0] fl_rd_n,
  input logic [NUM_BANK-1:0] fl_wr_n
);

  logic rd_act, wr_act, any_act;
  assign rd_act  = ~&fl_rd_n;
  assign wr_act  = ~&fl_wr_n;
  assign any_act = rd_act || wr_act;

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~fl_ce_n)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~{fl_rd_n, fl_wr_n}) <= 1); // R4

  AST_WR_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_act, 2) && $past(wr_act)) |-> !wr_act); // R5

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> !rd_act); // R6

  AST_CE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && any_act && !$past(any_act)) |-> ($past(fl_ce_n) != '1)); // R6

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && !any_act && $past(any_act)) |-> (fl_ce_n != '1)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !any_act); // R12

  AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_act)); // R12

endmodule

bind flash_window_ctrl fw_checker #(.NUM_CE(NUM_CE), .NUM_BANK(NUM_BANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode),
  .acc_ready(acc_ready), .rsp_valid(rsp_valid),
  .fl_ce_n(fl_ce_n), .fl_rd_n(fl_rd_n), .fl_wr_n(fl_wr_n)
);

// File: tb/sim_flash_window_ctrl.sv
`timescale 1ns/100ps
module sim_flash_window_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_prog = 1'b0;
  logic [15:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [24:0] fl_addr;
  logic [7:0]  fl_ce_n;
  logic [1:0]  fl_rd_n, fl_wr_n, fl_pd_n;
  logic [15:0] fl_wdata, fl_rdata;
  logic        fl_doe;
  logic        fl_rdy = 1'b0;

  always #2.5 clk = ~clk;

  // flash model: data depends on the address pins
  assign fl_rdata = (&fl_rd_n) ? 16'h0000 : (fl_addr[15:0] ^ 16'hC33C);

  flash_window_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_prog(acc_prog), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_rd_n(fl_rd_n), .fl_wr_n(fl_wr_n),
    .fl_wdata(fl_wdata), .fl_doe(fl_doe), .fl_rdata(fl_rdata), .fl_rdy(fl_rdy),
    .fl_pd_n(fl_pd_n)
  );

  typedef struct {
    bit          is_wr;
    logic [7:0]  ce_n;
    logic [3:0]  strb_n;
    logic [24:0] addr;
    logic [15:0] wdata;
    int          len;
    bit          has_rsp;
    logic [15:0] rsp;
    string       req;
  } exp_t;

  exp_t expq[$];
  int n_chk = 0, n_fail = 0, n_evt = 0, n_rsp = 0, n_rd_exp = 0;
  logic [9:0] m_rl = '0, m_wl = '0;
  logic [7:0] m_ctrl = 8'h8A;
  bit         m_pass = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_rl = d[9:0];
      2'd1: m_wl = d[9:0];
      2'd2: m_ctrl = d[7:0];
      default: m_pass = d[0];
    endcase
  endtask

  // driver: computes the expected flash cycle from the requirements and queues it
  task automatic access(input bit wr, input bit prog, input logic [15:0] a,
                        input logic [15:0] d, input string req);
    exp_t e;
    logic [9:0] lt;
    int idx;
    if (a[15]) begin
      lt = (wr || prog) ? m_wl : m_rl;
      idx = {lt[6], lt[5], lt[7]};
      e.is_wr = wr;
      e.ce_n = ~(8'b1 << idx);
      e.strb_n = wr ? {2'b11, ~(2'b01 << lt[8])} : {~(2'b01 << lt[8]), 2'b11};
      e.addr = {lt, a[14:0]};
      e.wdata = m_pass ? d : ~d;
      e.len = (wr && m_ctrl[0]) ? 2 : 1;
      e.has_rsp = !wr;
      e.rsp = m_pass ? ({lt[0], a[14:0]} ^ 16'hC33C) : ~({lt[0], a[14:0]} ^ 16'hC33C);
      e.req = req;
      expq.push_back(e);
      if (!wr) n_rd_exp++;
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_prog = prog; acc_addr = a; acc_wdata = d;
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    if (a[15]) chk("R12", "ready low while busy", {31'd0, acc_ready}, 32'd0);
    while (!acc_ready) @(negedge clk);
  endtask

  // monitor: pops the expected item when a strobe appears, compares it as it plays out
  initial begin
    bit act, prev = 1'b0, have = 1'b0;
    int len = 0;
    exp_t cur;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        act = !(&fl_rd_n) || !(&fl_wr_n);
        if (rsp_valid) n_rsp++;
        if (act && !prev) begin
          n_evt++;
          len = 1;
          if (expq.size() == 0) begin
            chk("R8", "unexpected strobe", {28'd0, fl_rd_n, fl_wr_n}, 32'hF);
            have = 1'b0;
          end else begin
            cur = expq.pop_front();
            have = 1'b1;
            chk(cur.req, "chip enable", {24'd0, fl_ce_n}, {24'd0, cur.ce_n});
            chk(cur.req, "strobe pins", {28'd0, fl_rd_n, fl_wr_n}, {28'd0, cur.strb_n});
            chk(cur.req, "address", {7'd0, fl_addr}, {7'd0, cur.addr});
            if (cur.is_wr) begin
              chk(cur.req, "write data", {16'd0, fl_wdata}, {16'd0, cur.wdata});
              chk(cur.req, "drive enable", {31'd0, fl_doe}, 32'd1);
            end
          end
        end else if (act) begin
          len++;
        end else if (prev && have) begin
          chk(cur.req, "strobe length", len, cur.len);
          chk({cur.req, " R6"}, "ce hold", {24'd0, fl_ce_n}, {24'd0, cur.ce_n});
          chk({cur.req, " R12"}, "rsp_valid", {31'd0, rsp_valid}, {31'd0, cur.has_rsp});
          if (cur.has_rsp) chk(cur.req, "read data", {16'd0, rsp_data}, {16'd0, cur.rsp});
          have = 1'b0;
        end
        prev = act;
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int evt0, rsp0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_sel = 2'd2;
    #0.1;
    chk("R10", "reset control", {16'd0, cfg_rdata}, 32'h008A);
    chk("R9", "ce idle sequential", {24'd0, fl_ce_n}, 32'hFF);
    chk("R4", "strobes idle", {28'd0, fl_rd_n, fl_wr_n}, 32'hF);
    chk("R11", "power down reset", {30'd0, fl_pd_n}, 32'h3);
    chk("R12", "ready after reset", {31'd0, acc_ready}, 32'd1);

    fl_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "ready status", {16'd0, cfg_rdata}, 32'h00CA);
    fl_rdy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "busy status", {16'd0, cfg_rdata}, 32'h008A);

    // sequential mode pins
    cfg_wr(2'd0, 16'h00B0);
    chk("R9", "CLE pin", {31'd0, fl_addr[19]}, 32'd1);
    chk("R9", "ALE pin", {31'd0, fl_addr[18]}, 32'd0);
    chk("R9", "ce gated off", {24'd0, fl_ce_n}, 32'hFF);
    cfg_wr(2'd2, 16'h008E);
    chk("R9", "ce select 101", {24'd0, fl_ce_n}, 32'hF7);
    cfg_wr(2'd0, 16'h0008);
    chk("R9", "CLE/ALE swap", {30'd0, fl_addr[19:18]}, 32'h1);
    chk("R3", "ce select 000", {24'd0, fl_ce_n}, 32'hFE);

    // power down outputs
    cfg_wr(2'd2, 16'h0008);
    chk("R11", "pd bank0 active", {30'd0, fl_pd_n}, 32'h2);
    cfg_wr(2'd2, 16'h0080);
    chk("R11", "pd bank1 active", {30'd0, fl_pd_n}, 32'h1);

    // random mode, one-clock writes
    cfg_wr(2'd2, 16'h0088);
    chk("R3", "ce idle random", {24'd0, fl_ce_n}, 32'hFF);

    for (int s = 0; s < 8; s++) begin
      cfg_wr(2'd0, 16'(((s & 1) << 8) | (s << 5) | 11));
      access(1'b0, 1'b0, 16'(16'h8000 + s * 16'h0913), 16'h0, "R1 R3 R4 R7");
    end

    cfg_wr(2'd3, 16'h0001);
    cfg_wr(2'd0, 16'h03E0);
    access(1'b0, 1'b0, 16'hFFFF, 16'h0, "R1 R7");
    access(1'b0, 1'b0, 16'h8001, 16'h0, "R1 R7");

    cfg_wr(2'd1, 16'h02E5);
    access(1'b1, 1'b0, 16'hC123, 16'h1234, "R2 R4 R5 R7");
    cfg_wr(2'd2, 16'h0089);
    cfg_wr(2'd1, 16'h0041);
    access(1'b1, 1'b0, 16'hA5A5, 16'hBEEF, "R2 R5");
    access(1'b1, 1'b0, 16'h8000, 16'h0F0F, "R2 R5");
    cfg_wr(2'd3, 16'h0000);
    access(1'b1, 1'b0, 16'hF00D, 16'h5AA5, "R5 R7");

    // fetch must take the write latch, which differs in ce, bank and bit 0
    cfg_wr(2'd0, 16'h0000);
    cfg_wr(2'd1, 16'h01A1);
    access(1'b0, 1'b1, 16'h9ABC, 16'h0, "R2 R6");

    // accesses below the window
    evt0 = n_evt; rsp0 = n_rsp;
    access(1'b0, 1'b0, 16'h7FFF, 16'h0, "R8");
    access(1'b1, 1'b0, 16'h0123, 16'hFFFF, "R8");
    access(1'b0, 1'b1, 16'h4000, 16'h0, "R8");
    repeat (4) @(negedge clk);
    chk("R8", "no strobe outside window", n_evt - evt0, 0);
    chk("R8", "no response outside window", n_rsp - rsp0, 0);
    chk("R8", "ce idle outside window", {24'd0, fl_ce_n}, 32'hFF);

    repeat (5) @(negedge clk);
    chk("R12", "all expected cycles seen", expq.size(), 0);
    chk("R12", "one response per read", n_rsp, n_rd_exp);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule